// File: doc/BRIEF.md
# Program/Erase Status Bit Generator

This block sits in the read return path of a nonvolatile memory model. While an embedded word program or erase is running it replaces two bits of the read word with status information. Host software can then poll completion by reading any location. It keeps one busy countdown, and the countdown is loaded with a duration chosen by the operation kind: word program, sector/block erase, or whole-array erase. The durations are parameters given in clock cycles. Real silicon needs tens of microseconds for a program and up to hundreds of milliseconds for an erase, so these parameters can be scaled down for simulation.

While busy, bit 7 of the read word is a polling bit and bit 6 is a toggle bit. The polling bit is the inverse of bit 7 of the word being programmed during a program, and it is 0 during any erase. The toggle bit changes value once per read access, not once per unit of time. When the countdown reaches zero, the block passes the array word through unchanged. After an erase that word is all ones, so the polling bit reads 1.

Top module: `pgm_status_gen`

## Requirements
- R1: After reset `busy` is 0 and `rd_data` equals `array_word`.
- R2: During a word program (`op_kind` = 2'b00), bit 7 of `rd_data` is the inverse of bit 7 of the `prog_word` captured at the start.
- R3: During a sector/block erase (`op_kind` = 2'b01) or a whole-array erase (`op_kind` = 2'b10), bit 7 of `rd_data` is 0.
- R4: While busy, bit 6 of `rd_data` changes value on the clock edge that samples a rising edge of `rd_strobe`, so consecutive read accesses see alternating values.
- R5: Every accepted start clears the toggle bit, so the first read of a new operation sees 0 on bit 6.
- R6: A `rd_strobe` that is held high advances the toggle bit only once.
- R7: An accepted start raises `busy` on the next clock edge. `busy` then stays high for exactly PROG_CYC, ERASE_CYC or CHIP_CYC cycles, according to `op_kind`.
- R8: While not busy, `rd_data` equals `array_word` on all 16 bits, whatever `rd_strobe` does. After an erase with an all-ones array this returns 1 on bit 7.
- R9: An `op_start` raised while busy is ignored: the running duration, the operation kind and the toggle sequence are not affected.
- R10: `op_kind` = 2'b11 is reserved, and a start with this code is not accepted (`busy` stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | One-cycle request to begin an internal operation |
| op_kind | input | 2 | 00 program, 01 sector/block erase, 10 whole-array erase, 11 reserved |
| prog_word | input | 16 | Word being programmed, sampled with the start |
| rd_strobe | input | 1 | Read access strobe; each rising edge is one access |
| array_word | input | 16 | Word read from the array at the current address |
| rd_data | output | 16 | Read data returned to the host |
| busy | output | 1 | High while an internal operation is running |

## Verification
The bench checks the length of each operation by counting busy cycles. A countdown that is off by one, or that picks the wrong duration for an operation kind, shows up as a count mismatch. The toggle bit is compared against a model at every cycle while the strobe is driven randomly, including strobes held high over several cycles and back-to-back operations. A design that toggles on the strobe level, or that does not clear the toggle bit on a new start, therefore reads the wrong bit 6. Starts issued in the middle of an operation and starts with the reserved code are mixed into the traffic. A design that restarts the countdown, or that changes the polling source, fails on duration or on bit 7. Idle cycles compare every bit against the array word.

// File: rtl/pgm_stat_pkg.sv
package pgm_stat_pkg;
  typedef enum logic [1:0] {
    OP_PROG  = 2'b00,
    OP_ERASE = 2'b01,
    OP_CHIP  = 2'b10,
    OP_RSVD  = 2'b11
  } op_kind_e;
endpackage

// File: rtl/busy_timer.sv
module busy_timer
  import pgm_stat_pkg::*;
#(
  parameter int unsigned PROG_CYC  = 40,
  parameter int unsigned ERASE_CYC = 100,
  parameter int unsigned CHIP_CYC  = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic [1:0] kind,
  output logic       accept,
  output logic       busy
);
  localparam int unsigned MAX_A = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned MAXC  = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;
  localparam int unsigned CW    = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q, cnt_d, load_val;
  logic          cnt_en;

  always_comb begin
    case (op_kind_e'(kind))
      OP_PROG:  load_val = CW'(PROG_CYC);
      OP_ERASE: load_val = CW'(ERASE_CYC);
      OP_CHIP:  load_val = CW'(CHIP_CYC);
      default:  load_val = '0;
    endcase
  end

  assign busy   = (cnt_q != '0);
  assign accept = start_req && !busy && (op_kind_e'(kind) != OP_RSVD);
  assign cnt_en = accept || busy;

  always_comb begin
    cnt_d = cnt_q;
    if (accept)    cnt_d = load_val;
    else if (busy) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  assert_end_on_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cnt_q) == CW'(1)));
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/toggle_gen.sv
module toggle_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic busy,
  input  logic rd_strobe,
  output logic tog
);
  logic strobe_q;
  logic tog_q, tog_d;
  logic rise;

  assign rise = rd_strobe && !strobe_q;

  always_comb begin
    tog_d = tog_q;
    if (accept)            tog_d = 1'b0;
    else if (busy && rise) tog_d = !tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      tog_q    <= 1'b0;
    end else begin
      strobe_q <= rd_strobe;
      tog_q    <= tog_d;
    end
  end

  assign tog = tog_q;

  assert_flip_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_strobe && !strobe_q && !accept) |=> (tog != $past(tog)));
  assert_clear_on_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !tog);
  assert_held_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && strobe_q && !accept) |=> $stable(tog));
endmodule

// File: rtl/op_context.sv
module op_context
  import pgm_stat_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [1:0]    kind,
  input  logic [DW-1:0] prog_word,
  input  logic          busy,
  input  logic          tog,
  input  logic [DW-1:0] array_word,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;

  logic is_prog_q, is_prog_d;
  logic bit7_q, bit7_d;
  logic poll;

  always_comb begin
    is_prog_d = is_prog_q;
    bit7_d    = bit7_q;
    if (accept) begin
      is_prog_d = (op_kind_e'(kind) == OP_PROG);
      bit7_d    = prog_word[POLL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_prog_q <= 1'b0;
      bit7_q    <= 1'b0;
    end else if (accept) begin
      is_prog_q <= is_prog_d;
      bit7_q    <= bit7_d;
    end
  end

  assign poll = is_prog_q ? !bit7_q : 1'b0;

  always_comb begin
    rd_data = array_word;
    if (busy) begin
      rd_data[POLL_BIT] = poll;
      rd_data[TOG_BIT]  = tog;
    end
  end

  assert_prog_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_kind_e'(kind) == OP_PROG) |=> (rd_data[POLL_BIT] == !$past(prog_word[POLL_BIT])));
  assert_erase_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_kind_e'(kind) != OP_PROG) |=> !rd_data[POLL_BIT]);
endmodule

// File: rtl/pgm_status_gen.sv
module pgm_status_gen #(
  parameter int unsigned PROG_CYC  = 40,
  parameter int unsigned ERASE_CYC = 100,
  parameter int unsigned CHIP_CYC  = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_start,
  input  logic [1:0]  op_kind,
  input  logic [15:0] prog_word,
  input  logic        rd_strobe,
  input  logic [15:0] array_word,
  output logic [15:0] rd_data,
  output logic        busy
);
  logic accept;
  logic tog;

  busy_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .CHIP_CYC(CHIP_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_req(op_start), .kind(op_kind),
    .accept(accept), .busy(busy)
  );

  toggle_gen u_tog (
    .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy),
    .rd_strobe(rd_strobe), .tog(tog)
  );

  op_context #(.DW(16)) u_ctx (
    .clk(clk), .rst_n(rst_n), .accept(accept), .kind(op_kind),
    .prog_word(prog_word), .busy(busy), .tog(tog),
    .array_word(array_word), .rd_data(rd_data)
  );

  assert_rsvd_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !busy && op_kind == 2'b11) |=> !busy);
endmodule

// File: tb/pgm_status_gen_tb_top.sv
module pgm_status_gen_tb_top;
  localparam int unsigned P_CYC = 12;
  localparam int unsigned E_CYC = 30;
  localparam int unsigned C_CYC = 50;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_start;
  logic [1:0]  op_kind;
  logic [15:0] prog_word;
  logic        rd_strobe;
  logic [15:0] array_word;
  logic [15:0] rd_data;
  logic        busy;

  int checks = 0;
  int fails  = 0;

  pgm_status_gen #(.PROG_CYC(P_CYC), .ERASE_CYC(E_CYC), .CHIP_CYC(C_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .prog_word(prog_word), .rd_strobe(rd_strobe), .array_word(array_word),
    .rd_data(rd_data), .busy(busy)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int unsigned dur_of(input logic [1:0] k);
    case (k)
      2'b00:   return P_CYC;
      2'b01:   return E_CYC;
      2'b10:   return C_CYC;
      default: return 0;
    endcase
  endfunction

  function automatic logic exp_poll(input logic [1:0] k, input logic [15:0] w);
    return (k == 2'b00) ? ~w[7] : 1'b0;
  endfunction

  task automatic run_op(input logic [1:0] k, input logic [15:0] w, input bit pokes);
    int unsigned cyc;
    logic exp_tog;
    logic prev_s;
    logic poke;
    @(negedge clk);
    op_start = 1'b1; op_kind = k; prog_word = w; rd_strobe = 1'b0;
    @(negedge clk);
    op_start = 1'b0;
    cyc = 0; exp_tog = 1'b0; prev_s = 1'b0;
    while (busy && cyc < 1000) begin
      cyc++;
      rd_strobe  = ($urandom_range(0, 2) != 0) ? ~prev_s : prev_s;
      array_word = 16'($urandom);
      poke = pokes && ($urandom_range(0, 5) == 0);
      if (poke) begin
        op_start  = 1'b1;
        op_kind   = 2'($urandom);
        prog_word = 16'($urandom);
      end
      #1;
      chk(rd_data[7] == exp_poll(k, w), "R2/R3 poll bit", rd_data[7], exp_poll(k, w));
      chk(rd_data[6] == exp_tog, "R4/R5/R6 toggle bit", rd_data[6], exp_tog);
      if (rd_strobe && !prev_s) exp_tog = ~exp_tog;
      prev_s = rd_strobe;
      @(negedge clk);
      op_start = 1'b0;
    end
    chk(cyc == dur_of(k), "R7/R9 busy length", cyc, dur_of(k));
    rd_strobe = 1'b0;
  endtask

  task automatic idle_check(input int n, input bit erased);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_strobe  = 1'($urandom);
      array_word = erased ? 16'hFFFF : 16'($urandom);
      #1;
      chk(rd_data == array_word && !busy, "R8 idle passthrough", rd_data, array_word);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd2718);
    rst_n = 1'b0; op_start = 1'b0; op_kind = 2'b00; prog_word = '0;
    rd_strobe = 1'b0; array_word = 16'h1234;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy, "R1 reset busy", busy, 0);
    chk(rd_data == 16'h1234, "R1 reset passthrough", rd_data, 16'h1234);
    rst_n = 1'b1;
    idle_check(5, 1'b0);

    run_op(2'b00, 16'h0080, 1'b0);
    run_op(2'b00, 16'h0000, 1'b0);
    run_op(2'b01, 16'hFFFF, 1'b0);
    idle_check(3, 1'b1);
    chk(rd_data[7] == 1'b1, "R8 erased poll bit", rd_data[7], 1);
    run_op(2'b10, 16'h0000, 1'b0);
    idle_check(3, 1'b1);

    @(negedge clk);
    op_start = 1'b1; op_kind = 2'b11;
    @(negedge clk);
    op_start = 1'b0;
    #1;
    chk(!busy, "R10 reserved start", busy, 0);
    idle_check(3, 1'b0);

    for (int n = 0; n < 40; n++) begin
      logic [1:0] k;
      k = 2'($urandom_range(0, 2));
      run_op(k, 16'($urandom), 1'b1);
      idle_check($urandom_range(1, 4), k != 2'b00);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule